// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral supervises software by counting down from a programmed reload value. It sits on a plain register bus with one address port, a write strobe, write data and combinational read data. The count moves by one on each pulse of a counter-clock enable input, so the tick rate is set outside the block. Software keeps the count from expiring by writing two fixed key words, in order, to the service register. When the count runs out, the block drives a one-cycle reset pulse and then reloads.

Four registers are decoded, at byte offsets 0x00 (control), 0x08 (timeout), 0x10 (service) and 0x14 (live count). The control register holds these fields:
- bit 0: enable.
- bit 1: freeze while the debug-halt input is high.
- bit 2: halt while the low-power stop input is high.
- bits 10:9: service mode. Only 00, the fixed key pair, is implemented.

Two small state machines carry the behaviour. The key tracker has states SEQ_IDLE and SEQ_ARMED:
- SEQ_IDLE→SEQ_ARMED on first key.
- SEQ_ARMED→SEQ_IDLE on second key, which refreshes the count.
- SEQ_ARMED→SEQ_IDLE on any other word.
- SEQ_ARMED→SEQ_ARMED on a repeated first key.
- Any state→SEQ_IDLE while disabled.

The count engine has states CNT_HALT, CNT_RUN and CNT_FIRE:
- CNT_HALT→CNT_RUN on enable load.
- CNT_RUN→CNT_HALT when disabled.
- CNT_RUN→CNT_FIRE on the tick that takes the count from 1 to 0.
- CNT_FIRE→CNT_RUN, or CNT_FIRE→CNT_HALT if disabled, reloading on the way.

Top module: `svcwd_top`

## Requirements
- R1: After reset, control reads 0, timeout reads 0x00000100, count (0x14) reads 0x00000100 and `wdt_reset` is low.
- R2: Control bits 0, 1, 2 and 10:9 are writable and read back; all other control bits read 0.
- R3: A control write that sets bit 0 while the watchdog is disabled loads the count from the timeout register. Writing the timeout register alone leaves a running count unchanged.
- R4: While enabled and not held, the count drops by one for each cycle in which `cnt_tick` is high.
- R5: A timeout value below 0x100 is loaded as 0x100.
- R6: Writing 0x0000A602 then 0x0000B480 to the service register (offset 0x10) reloads the count from the timeout register.
- R7: A word other than 0x0000B480 written right after 0x0000A602 cancels the sequence without a reload. A write of 0x0000A602 always re-arms the sequence.
- R8: Service writes have no effect while the watchdog is disabled or while the service-mode field (bits 10:9) is not 00.
- R9: Reading offset 0x14 returns 0 while enabled and the held count while disabled.
- R10: While disabled the count holds its value.
- R11: With control bit 1 set, the count holds while `dbg_halt` is high; with bit 1 clear it keeps counting.
- R12: With control bit 2 set, the count holds while `stop_req` is high; with bit 2 clear it keeps counting.
- R13: The tick that takes the count to 0 raises `wdt_reset` for exactly one cycle, starting on the next edge. The count then reloads from the timeout register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Counter clock enable, one decrement per high cycle |
| dbg_halt | input | 1 | Debug halt request |
| stop_req | input | 1 | Low-power stop request |
| wdt_reset | output | 1 | One-cycle timeout reset pulse |

## Verification
The bound checker enforces these rules on every cycle:
- The reset pulse lasts a single cycle, and the count is zero while it is high.
- Every load leaves at least 0x100 in the count.
- The count does not move while disabled, or while frozen by debug halt.
- The live-count register reads zero whenever the watchdog runs.

Only the bench scenarios can show the following:
- The exact count after a given number of ticks.
- That the key words must arrive in order, and that a wrong word or a non-zero service mode suppresses the reload.
- That a timeout write does not disturb a running count.
- The cycle in which the pulse appears after a full countdown.

// File: rtl/svcwd_pkg.sv
package svcwd_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_TMO   = 8'h08;
    localparam logic [7:0] OFS_SVC   = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h14;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_A602;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_B480;

    localparam int BIT_EN   = 0;
    localparam int BIT_FRZ  = 1;
    localparam int BIT_STP  = 2;
    localparam int MODE_LSB = 9;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ARMED
    } seq_state_e;

    typedef enum logic [1:0] {
        CNT_HALT,
        CNT_RUN,
        CNT_FIRE
    } cnt_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       stp;
        logic       frz;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/svcwd_regs.sv
module svcwd_regs
    import svcwd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int RST_TMO  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_q,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  tmo_val,
    output logic              en_rise,
    output logic              svc_wr
);
    logic hit_ctrl, hit_tmo, hit_svc, hit_count;

    always_comb begin
        hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_tmo   = (bus_addr == ADDR_W'(OFS_TMO));
        hit_svc   = (bus_addr == ADDR_W'(OFS_SVC));
        hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
    end

    always_comb begin
        en_rise = bus_wr && hit_ctrl && bus_wdata[BIT_EN] && !ctrl.en;
        svc_wr  = bus_wr && hit_svc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            tmo_val <= CNT_W'(RST_TMO);
        end else if (bus_wr) begin
            if (hit_ctrl) begin
                ctrl.en   <= bus_wdata[BIT_EN];
                ctrl.frz  <= bus_wdata[BIT_FRZ];
                ctrl.stp  <= bus_wdata[BIT_STP];
                ctrl.mode <= bus_wdata[MODE_LSB+1:MODE_LSB];
            end
            if (hit_tmo) begin
                tmo_val <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_EN]              = ctrl.en;
            bus_rdata[BIT_FRZ]             = ctrl.frz;
            bus_rdata[BIT_STP]             = ctrl.stp;
            bus_rdata[MODE_LSB+1:MODE_LSB] = ctrl.mode;
        end else if (hit_tmo) begin
            bus_rdata = DATA_W'(tmo_val);
        end else if (hit_count) begin
            bus_rdata = ctrl.en ? '0 : DATA_W'(count_q);
        end
    end
endmodule

// File: rtl/svcwd_seq.sv
module svcwd_seq
    import svcwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              refresh,
    output seq_state_e        seq_state
);
    seq_state_e seq_next;
    logic       is_first, is_second;

    always_comb begin
        is_first  = (svc_data == KEY_FIRST);
        is_second = (svc_data == KEY_SECOND);
    end

    always_comb begin
        seq_next = seq_state;
        if (!active) begin
            seq_next = SEQ_IDLE;
        end else if (svc_wr) begin
            unique case (seq_state)
                SEQ_IDLE:  seq_next = is_first ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED: seq_next = is_first ? SEQ_ARMED : SEQ_IDLE;
                default:   seq_next = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_state <= SEQ_IDLE;
        else        seq_state <= seq_next;
    end

    always_comb begin
        refresh = active && svc_wr && is_second && (seq_state == SEQ_ARMED);
    end
endmodule

// File: rtl/svcwd_counter.sv
module svcwd_counter
    import svcwd_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int MIN_LOAD = 256,
    parameter int RST_CNT  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             advance,
    input  logic             load,
    input  logic [CNT_W-1:0] tmo_val,
    output logic [CNT_W-1:0] count_q,
    output cnt_state_e       cnt_state,
    output logic             fire
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] load_val;
    cnt_state_e       cnt_next;

    generate
        if (MIN_LOAD > 0) begin : g_clamp
            always_comb load_val = (tmo_val < FLOOR) ? FLOOR : tmo_val;
        end else begin : g_noclamp
            always_comb load_val = tmo_val;
        end
    endgenerate

    always_comb begin
        cnt_next = cnt_state;
        unique case (cnt_state)
            CNT_HALT: if (load) cnt_next = CNT_RUN;
            CNT_RUN: begin
                if (load)                          cnt_next = CNT_RUN;
                else if (!en)                      cnt_next = CNT_HALT;
                else if (advance && count_q == ONE) cnt_next = CNT_FIRE;
            end
            CNT_FIRE: cnt_next = en ? CNT_RUN : CNT_HALT;
            default:  cnt_next = CNT_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_state <= CNT_HALT;
        else        cnt_state <= cnt_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RST_CNT);
        end else if (load) begin
            count_q <= load_val;
        end else begin
            unique case (cnt_state)
                CNT_RUN:  if (en && advance) count_q <= count_q - ONE;
                CNT_FIRE: count_q <= load_val;
                default:  count_q <= count_q;
            endcase
        end
    end

    always_comb begin
        fire = (cnt_state == CNT_FIRE);
    end
endmodule

// File: rtl/svcwd_top.sv
module svcwd_top
    import svcwd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int MIN_LOAD = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cnt_tick,
    input  logic              dbg_halt,
    input  logic              stop_req,
    output logic              wdt_reset
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] tmo_val;
    logic [CNT_W-1:0] count_q;
    logic             en_rise, svc_wr, refresh, load, advance, fire, svc_active;
    seq_state_e       seq_state;
    cnt_state_e       cnt_state;

    svcwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_TMO(MIN_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_q(count_q),
        .ctrl(ctrl), .tmo_val(tmo_val), .en_rise(en_rise), .svc_wr(svc_wr)
    );

    always_comb begin
        svc_active = ctrl.en && (ctrl.mode == 2'b00);
        load       = en_rise || refresh;
        advance    = cnt_tick && !(ctrl.frz && dbg_halt) && !(ctrl.stp && stop_req);
    end

    svcwd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .active(svc_active), .svc_wr(svc_wr),
        .svc_data(bus_wdata), .refresh(refresh), .seq_state(seq_state)
    );

    svcwd_counter #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD), .RST_CNT(MIN_LOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .advance(advance), .load(load),
        .tmo_val(tmo_val), .count_q(count_q), .cnt_state(cnt_state), .fire(fire)
    );

    always_comb begin
        wdt_reset = fire;
    end
endmodule

// File: rtl/svcwd_checker.sv
module svcwd_checker #(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int MIN_LOAD = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              dbg_halt,
    input logic              wdt_reset,
    input logic              en,
    input logic              frz,
    input logic              en_rise,
    input logic              load,
    input logic [CNT_W-1:0]  count_q
);
    localparam logic [ADDR_W-1:0] COUNT_OFS = ADDR_W'(8'h14);

    p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);

    p_pulse_at_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> (count_q == '0));

    p_load_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q >= CNT_W'(MIN_LOAD)));

    p_hidden_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_addr == COUNT_OFS) |-> (bus_rdata == '0));

    p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !en_rise && !wdt_reset) |=> $stable(count_q));

    p_debug_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frz && dbg_halt && !load && !wdt_reset) |=> $stable(count_q));
endmodule

bind svcwd_top svcwd_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .wdt_reset(wdt_reset), .en(ctrl.en), .frz(ctrl.frz),
    .en_rise(en_rise), .load(load), .count_q(count_q)
);

// File: tb/svcwd_top_test.sv
module svcwd_top_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        cnt_tick = 0, dbg_halt = 0, stop_req = 0;
    logic        wdt_reset;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] v;

    localparam logic [7:0] A_CTRL = 8'h00, A_TMO = 8'h08, A_SVC = 8'h10, A_CNT = 8'h14;

    always #2.5 clk = ~clk;

    svcwd_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
        .dbg_halt(dbg_halt), .stop_req(stop_req), .wdt_reset(wdt_reset)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); cnt_tick = 1; end
        @(negedge clk); cnt_tick = 0;
    endtask

    task automatic stop_and_read(logic [31:0] ctl, output logic [31:0] d);
        wr(A_CTRL, ctl & ~32'h1);
        rd(A_CNT, d);
    endtask

    task automatic t_reset;
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_TMO, v);  check("R1 timeout", v, 32'h100);
        rd(A_CNT, v);  check("R1 count", v, 32'h100);
        check("R1 pulse", {31'b0, wdt_reset}, 0);
    endtask

    task automatic t_ctrl_bits;
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check("R2 mask", v, 32'h606);
        wr(A_CTRL, 32'h0000_0204); rd(A_CTRL, v); check("R2 readback", v, 32'h204);
        wr(A_CTRL, 0);
    endtask

    task automatic t_count_and_load;
        wr(A_TMO, 32'h300); wr(A_CTRL, 1);
        rd(A_CNT, v); check("R9 hidden", v, 0);
        ticks(40);
        wr(A_TMO, 32'h500);
        stop_and_read(1, v); check("R4 R3 running", v, 32'h300 - 40);
        ticks(7);
        rd(A_CNT, v); check("R10 hold", v, 32'h300 - 40);
        wr(A_CTRL, 1); stop_and_read(1, v); check("R3 enable load", v, 32'h500);
    endtask

    task automatic t_clamp;
        wr(A_TMO, 32'h10); wr(A_CTRL, 1);
        stop_and_read(1, v); check("R5 clamp", v, 32'h100);
        wr(A_TMO, 32'h0); wr(A_CTRL, 1); ticks(3);
        stop_and_read(1, v); check("R5 clamp zero", v, 32'h100 - 3);
    endtask

    task automatic t_service;
        wr(A_TMO, 32'h400); wr(A_CTRL, 1); ticks(20);
        wr(A_SVC, 32'hA602); wr(A_SVC, 32'hB480);
        stop_and_read(1, v); check("R6 refresh", v, 32'h400);
        wr(A_CTRL, 1); ticks(10);
        wr(A_SVC, 32'hA602); wr(A_SVC, 32'h1234); wr(A_SVC, 32'hB480);
        stop_and_read(1, v); check("R7 abort", v, 32'h400 - 10);
        wr(A_CTRL, 1); ticks(10);
        wr(A_SVC, 32'hB480);
        stop_and_read(1, v); check("R7 lone second", v, 32'h400 - 10);
        wr(A_CTRL, 1); ticks(10);
        wr(A_SVC, 32'hA602); wr(A_SVC, 32'hA602); wr(A_SVC, 32'hB480);
        stop_and_read(1, v); check("R7 rearm", v, 32'h400);
    endtask

    task automatic t_ignored;
        wr(A_TMO, 32'h200);
        wr(A_SVC, 32'hA602);
        wr(A_CTRL, 1); ticks(5);
        wr(A_SVC, 32'hB480);
        stop_and_read(1, v); check("R8 disabled key", v, 32'h200 - 5);
        wr(A_SVC, 32'hA602); wr(A_SVC, 32'hB480);
        rd(A_CNT, v); check("R8 disabled pair", v, 32'h200 - 5);
        wr(A_CTRL, 32'h201); ticks(5);
        wr(A_SVC, 32'hA602); wr(A_SVC, 32'hB480);
        stop_and_read(32'h201, v); check("R8 mode01", v, 32'h200 - 5);
        wr(A_CTRL, 0);
    endtask

    task automatic t_holds;
        wr(A_TMO, 32'h200);
        dbg_halt = 1;
        wr(A_CTRL, 3); ticks(10);
        stop_and_read(3, v); check("R11 frozen", v, 32'h200);
        wr(A_CTRL, 1); ticks(10);
        stop_and_read(1, v); check("R11 not frozen", v, 32'h200 - 10);
        dbg_halt = 0; stop_req = 1;
        wr(A_CTRL, 5); ticks(10);
        stop_and_read(5, v); check("R12 stopped", v, 32'h200);
        wr(A_CTRL, 1); ticks(10);
        stop_and_read(1, v); check("R12 keeps running", v, 32'h200 - 10);
        stop_req = 0;
        wr(A_CTRL, 0);
    endtask

    task automatic t_expire;
        wr(A_TMO, 32'h100); wr(A_CTRL, 1);
        ticks(255);
        #1 check("R13 before zero", {31'b0, wdt_reset}, 0);
        ticks(1);
        #1 check("R13 pulse", {31'b0, wdt_reset}, 1);
        @(negedge clk); #1 check("R13 one cycle", {31'b0, wdt_reset}, 0);
        stop_and_read(1, v); check("R13 reload", v, 32'h100);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_ctrl_bits();
                t_count_and_load();
                t_clamp();
                t_service();
                t_ignored();
                t_holds();
                t_expire();
            end
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule